// File: doc/BRIEF.md
# Straddled Completion Stream Splitter

This block takes a 256-bit completion stream in which a single beat may carry the tail of one TLP and the head of the next. The input has no last signal. TLP boundaries come from sideband flags instead: two start flags and two end codes, each end code holding an end bit and a 3-bit last-Dword index. The block turns this stream into an ordinary packet stream that holds one TLP per packet. Each output beat carries per-Dword keep bits, a last flag and a discard flag.

Dwords stay in the lanes where they arrived; no data is shifted. A TLP can begin only at Dword 0 or at Dword 4. When a beat closes one TLP and opens another at Dword 4, the block sends two output beats for it: first the closing TLP with last set, then the opening part of the next TLP. Input ready stays low until the second beat has been sent. Both sides use valid/ready handshaking, and the output holds its beat stable while it is stalled.

Top module: `cpl_straddle_split`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: A beat inside a TLP that neither starts nor ends that TLP produces one output beat with all 8 keep bits set and last low.
- R3: With no TLP open, a beat with in_sof0_i set opens a TLP at Dword 0, and its output beat keeps Dwords from 0 upward.
- R4: When in_eof0_i[0] is set, the TLP ending first in the beat produces an output beat with keep set for Dwords 0 through in_eof0_i[3:1] only, and last high.
- R5: A TLP that starts at Dword 4 of a beat in which an earlier TLP has ended gets its own output beat, with keep starting at Dword 4. This start is flagged by in_sof1_i when the earlier TLP also started in the beat, and by in_sof0_i when it continued from a previous beat. If in_eof1_i[0] is set, keep covers Dwords 4 through in_eof1_i[3:1] and last is high; otherwise it covers Dwords 4 to 7 and last is low.
- R6: A beat holding two TLP segments yields two output beats in stream order, both carrying the input beat's data. in_ready_o stays low while the first of them is on the output.
- R7: When in_discont_i is set on a beat, the output beat that ends the first TLP carries out_discard_o high. No other output beat carries it, and no second TLP is started from that beat.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o, out_keep_o, out_last_o and out_discard_o hold their values.
- R9: An input beat taken while no TLP is open and with in_sof0_i low produces no output beat.
- R10: out_data_o equals the 256-bit data of the input beat it came from, with every Dword in its original lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 256 | Input beat data, 8 Dwords |
| in_sof0_i | input | 1 | A TLP starts in this beat (Dword 0, or Dword 4 if a TLP continues into the beat) |
| in_sof1_i | input | 1 | A second TLP starts at Dword 4 |
| in_eof0_i | input | 4 | Bit 0: first TLP ends here; bits 3:1: index of its last Dword |
| in_eof1_i | input | 4 | Bit 0: second TLP ends here; bits 3:1: index of its last Dword |
| in_discont_i | input | 1 | The TLP ending first in this beat must be discarded |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| out_data_o | output | 256 | Output beat data |
| out_keep_o | output | 8 | Per-Dword keep bits |
| out_last_o | output | 1 | Last beat of the packet |
| out_discard_o | output | 1 | Packet must be dropped (on the last beat) |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The assertions check on every cycle the properties that can be seen on a single output beat or a single stall. They check that the output holds while stalled, that discard appears only together with last, that a beat which is not last keeps its top Dword, and that a beat starting late always keeps Dword 4. Other behaviours only show up against a known TLP stream, so the bench's scenarios cover them. These are the exact keep ranges taken from the end codes, the choice between the two start flags for a late start, the dropping of beats with no open TLP, the ordering and duplicated data of split beats, and the input stall during a split. The bench packs random TLP lengths and discontinue marks into straddled beats and predicts each output beat from that packing.

// File: rtl/cpl_split_pkg.sv
package cpl_split_pkg;
  localparam int unsigned DWORD_BITS = 32;
  localparam int unsigned BEAT_DWORDS = 8;
endpackage

// File: rtl/cpl_lane_mask.sv
module cpl_lane_mask #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [IW-1:0] lo_i,
  input  logic [IW-1:0] hi_i,
  output logic [N-1:0]  mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign mask_o[g] = (IW'(g) >= lo_i) && (IW'(g) <= hi_i);
  end
endmodule

// File: rtl/cpl_beat_decode.sv
module cpl_beat_decode #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned HALF = N / 2
) (
  input  logic         open_i,
  input  logic         sof0_i,
  input  logic         sof1_i,
  input  logic [IW:0]  eof0_i,
  input  logic [IW:0]  eof1_i,
  input  logic         disc_i,
  output logic         a_valid_o,
  output logic [N-1:0] a_keep_o,
  output logic         a_last_o,
  output logic         a_discard_o,
  output logic         b_valid_o,
  output logic [N-1:0] b_keep_o,
  output logic         b_last_o,
  output logic         next_open_o
);
  logic [N-1:0]  mask_a, mask_b;
  logic [IW-1:0] b_hi;
  logic          late_start;

  assign b_hi = eof1_i[0] ? eof1_i[IW:1] : IW'(N - 1);

  cpl_lane_mask #(.N(N)) u_mask_a (.lo_i('0), .hi_i(eof0_i[IW:1]), .mask_o(mask_a));
  cpl_lane_mask #(.N(N)) u_mask_b (.lo_i(IW'(HALF)), .hi_i(b_hi), .mask_o(mask_b));

  // a continuing TLP flags the late start on sof0, a fresh one on sof1
  assign late_start = eof0_i[0] && !disc_i && (open_i ? sof0_i : sof1_i);

  always_comb begin
    a_valid_o   = open_i || sof0_i;
    a_keep_o    = eof0_i[0] ? mask_a : '1;
    a_last_o    = eof0_i[0];
    a_discard_o = eof0_i[0] && disc_i;
    b_valid_o   = a_valid_o && late_start;
    b_keep_o    = mask_b;
    b_last_o    = eof1_i[0];
    if (!a_valid_o)      next_open_o = 1'b0;
    else if (!eof0_i[0]) next_open_o = 1'b1;
    else                 next_open_o = late_start && !eof1_i[0];
  end
endmodule

// File: rtl/cpl_out_stage.sv
module cpl_out_stage #(
  parameter int unsigned N = 8,
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              accept_o,
  input  logic              a_valid_i,
  input  logic [N-1:0]      a_keep_i,
  input  logic              a_last_i,
  input  logic              a_discard_i,
  input  logic              b_valid_i,
  input  logic [N-1:0]      b_keep_i,
  input  logic              b_last_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [N-1:0]      out_keep_o,
  output logic              out_last_o,
  output logic              out_discard_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  logic         pend_q;
  logic [N-1:0] pend_keep_q;
  logic         pend_last_q;
  logic         slot_free;

  assign slot_free  = !out_valid_o || out_ready_i;
  assign in_ready_o = slot_free && !pend_q;
  assign accept_o   = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o    <= '0;
      out_keep_o    <= '0;
      out_last_o    <= 1'b0;
      out_discard_o <= 1'b0;
      out_valid_o   <= 1'b0;
      pend_q        <= 1'b0;
      pend_keep_q   <= '0;
      pend_last_q   <= 1'b0;
    end else if (slot_free) begin
      if (pend_q) begin
        // second half of a split beat: same data, new framing
        out_keep_o    <= pend_keep_q;
        out_last_o    <= pend_last_q;
        out_discard_o <= 1'b0;
        out_valid_o   <= 1'b1;
        pend_q        <= 1'b0;
      end else if (in_valid_i) begin
        out_valid_o <= a_valid_i;
        if (a_valid_i) begin
          out_data_o    <= in_data_i;
          out_keep_o    <= a_keep_i;
          out_last_o    <= a_last_i;
          out_discard_o <= a_discard_i;
        end
        pend_q      <= a_valid_i && b_valid_i;
        pend_keep_q <= b_keep_i;
        pend_last_q <= b_last_i;
      end else begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpl_straddle_split.sv
module cpl_straddle_split #(
  parameter int unsigned NUM_DW = cpl_split_pkg::BEAT_DWORDS,
  parameter int unsigned DW_BITS = cpl_split_pkg::DWORD_BITS,
  localparam int unsigned DATA_W = NUM_DW * DW_BITS,
  localparam int unsigned IW = $clog2(NUM_DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof0_i,
  input  logic              in_sof1_i,
  input  logic [IW:0]       in_eof0_i,
  input  logic [IW:0]       in_eof1_i,
  input  logic              in_discont_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [NUM_DW-1:0] out_keep_o,
  output logic              out_last_o,
  output logic              out_discard_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  logic              open_q, next_open, accept;
  logic              a_valid, a_last, a_discard, b_valid, b_last;
  logic [NUM_DW-1:0] a_keep, b_keep;

  cpl_beat_decode #(.N(NUM_DW)) u_dec (
    .open_i(open_q), .sof0_i(in_sof0_i), .sof1_i(in_sof1_i),
    .eof0_i(in_eof0_i), .eof1_i(in_eof1_i), .disc_i(in_discont_i),
    .a_valid_o(a_valid), .a_keep_o(a_keep), .a_last_o(a_last), .a_discard_o(a_discard),
    .b_valid_o(b_valid), .b_keep_o(b_keep), .b_last_o(b_last),
    .next_open_o(next_open)
  );

  cpl_out_stage #(.N(NUM_DW), .DATA_W(DATA_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .accept_o(accept),
    .a_valid_i(a_valid), .a_keep_i(a_keep), .a_last_i(a_last), .a_discard_i(a_discard),
    .b_valid_i(b_valid), .b_keep_i(b_keep), .b_last_i(b_last),
    .out_data_o(out_data_o), .out_keep_o(out_keep_o), .out_last_o(out_last_o),
    .out_discard_o(out_discard_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_q <= 1'b0;
    else if (accept) open_q <= next_open;
  end
endmodule

// File: rtl/cpl_straddle_split_chk.sv
module cpl_straddle_split_chk #(
  parameter int unsigned NUM_DW = 8,
  parameter int unsigned DATA_W = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] out_data_o,
  input logic [NUM_DW-1:0] out_keep_o,
  input logic              out_last_o,
  input logic              out_discard_o,
  input logic              out_valid_o,
  input logic              out_ready_i
);
  localparam int unsigned HALF = NUM_DW / 2;

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_keep_o)
      && $stable(out_last_o) && $stable(out_discard_o));

  // R7
  discard_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_discard_o |-> out_last_o);

  // R2
  open_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_last_o |-> out_keep_o[NUM_DW-1]);

  // R5
  late_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_keep_o[0] |-> out_keep_o[HALF]);

  // R4
  keep_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(out_keep_o) > 0);
endmodule

bind cpl_straddle_split cpl_straddle_split_chk #(.NUM_DW(NUM_DW), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_data_o(out_data_o), .out_keep_o(out_keep_o),
  .out_last_o(out_last_o), .out_discard_o(out_discard_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i)
);

// File: tb/tb_cpl_straddle_split.sv
`timescale 1ns/1ps
module tb_cpl_straddle_split;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [255:0] in_data_i;
  logic         in_sof0_i, in_sof1_i, in_discont_i, in_valid_i;
  logic [3:0]   in_eof0_i, in_eof1_i;
  logic         in_ready_o;
  logic [255:0] out_data_o;
  logic [7:0]   out_keep_o;
  logic         out_last_o, out_discard_o, out_valid_o, out_ready_i;

  always #2 clk_i = ~clk_i;

  cpl_straddle_split dut (.*);

  typedef struct {
    logic [255:0] d;
    logic [7:0]   k;
    logic         l;
    logic         x;
    logic         sp;
    string        tag;
  } exp_t;

  exp_t         exp_q[$];
  logic [255:0] bd_q[$];
  logic [10:0]  bf_q[$];  // {sof0, sof1, eof0[3:0], eof1[3:0], disc}

  int errs = 0, checks = 0;

  // beat under construction
  logic [255:0] cd;
  logic         c_sof0, c_sof1, c_disc, c_cont;
  logic [3:0]   c_eof0, c_eof1;
  int           pos;

  function automatic logic [7:0] rng(int lo, int hi);
    logic [7:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic new_beat();
    cd = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    c_sof0 = 0; c_sof1 = 0; c_disc = 0; c_cont = 0; c_eof0 = 0; c_eof1 = 0; pos = 0;
  endtask

  task automatic emit_beat();
    bd_q.push_back(cd);
    bf_q.push_back({c_sof0, c_sof1, c_eof0, c_eof1, c_disc});
    new_beat();
  endtask

  task automatic push_exp(logic [7:0] k, logic l, logic x, string tag);
    exp_t e;
    e.d = cd; e.k = k; e.l = l; e.x = x; e.sp = 1'b0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic add_tlp(int len, bit disc, bit straddle);
    int s, rem, e;
    bit second, first_seg;
    if (pos == 0) s = 0;
    else if (straddle && pos <= 4 && !c_disc) begin
      s = 4;
      if (c_cont) c_sof0 = 1; else c_sof1 = 1;
      exp_q[exp_q.size()-1].sp = 1'b1;  // R6: previous segment shares this beat
    end else begin
      emit_beat();
      s = 0;
    end
    second = (s == 4);
    if (s == 0) c_sof0 = 1;
    rem = len;
    first_seg = 1;
    forever begin
      if (rem > 8 - s) begin
        push_exp(rng(s, 7), 0, 0, second ? "R5" : (first_seg ? "R3" : "R2"));
        rem -= 8 - s;
        emit_beat();
        c_cont = 1; s = 0; second = 0; first_seg = 0;
      end else begin
        e = s + rem - 1;
        if (second) begin
          c_eof1 = {3'(e), 1'b1};
          push_exp(rng(s, e), 1, 0, "R5");
        end else begin
          c_eof0 = {3'(e), 1'b1};
          c_disc = disc;
          push_exp(rng(s, e), 1, disc, disc ? "R7" : "R4");
        end
        pos = e + 1;
        if (pos == 8) emit_beat();
        break;
      end
    end
  endtask

  initial begin : watchdog
    #400000;
    errs++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int bi, cyc;
    bit in_fire, out_fire, stall_prev;
    logic [255:0] s_d; logic [7:0] s_k; logic s_l, s_x;
    exp_t h;
    void'($urandom(32'h5eed));
    rst_ni = 0; in_valid_i = 0; out_ready_i = 0; in_data_i = '0;
    in_sof0_i = 0; in_sof1_i = 0; in_eof0_i = 0; in_eof1_i = 0; in_discont_i = 0;

    // R9: a flagless beat with nothing open, expected to vanish
    new_beat();
    emit_beat();
    // directed corners
    add_tlp(3, 0, 1); add_tlp(2, 0, 1);    // fresh split, sof1 start (R5, R6)
    add_tlp(10, 0, 1); add_tlp(12, 0, 1);  // continuation then sof0 late start
    add_tlp(2, 1, 1); add_tlp(5, 0, 1);    // discontinue blocks straddle (R7)
    add_tlp(1, 0, 1); add_tlp(4, 0, 1);    // late start ending at Dword 7
    for (int i = 0; i < 70; i++)
      add_tlp(1 + int'($urandom % 20), ($urandom % 8) == 0, ($urandom % 4) != 0);
    if (pos != 0) emit_beat();

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    checks++;  // R1
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      errs++;
      $display("FAIL R1 reset state: valid=%b ready=%b expected valid=0 ready=1", out_valid_o, in_ready_o);
    end

    bi = 0; cyc = 0; in_fire = 0; stall_prev = 0;
    while (!(bi == bd_q.size() && exp_q.size() == 0 && !out_valid_o) && cyc < 20000) begin
      @(posedge clk_i); #1;
      if (in_fire) bi++;
      if (!in_valid_i || in_fire) begin
        in_valid_i = (bi < bd_q.size()) && (($urandom % 4) != 0);
        if (bi < bd_q.size()) begin
          in_data_i = bd_q[bi];
          {in_sof0_i, in_sof1_i, in_eof0_i, in_eof1_i, in_discont_i} = bf_q[bi];
        end
      end
      out_ready_i = ($urandom % 3) != 0;
      @(negedge clk_i);
      if (stall_prev) begin
        checks++;  // R8
        if (!out_valid_o || out_data_o !== s_d || out_keep_o !== s_k || out_last_o !== s_l || out_discard_o !== s_x) begin
          errs++;
          $display("FAIL R8 stall hold: keep=%h last=%b got, keep=%h last=%b expected", out_keep_o, out_last_o, s_k, s_l);
        end
      end
      stall_prev = out_valid_o && !out_ready_i;
      s_d = out_data_o; s_k = out_keep_o; s_l = out_last_o; s_x = out_discard_o;
      in_fire  = in_valid_i && in_ready_o;
      out_fire = out_valid_o && out_ready_i;
      if (out_fire) begin
        checks++;
        if (exp_q.size() == 0) begin
          errs++;
          $display("FAIL R9 unexpected output beat keep=%h, expected none", out_keep_o);
        end else begin
          h = exp_q.pop_front();
          if (out_keep_o !== h.k || out_last_o !== h.l || out_discard_o !== h.x || out_data_o !== h.d) begin
            errs++;
            $display("FAIL %s (R10 data) keep=%h last=%b discard=%b data_ok=%b expected keep=%h last=%b discard=%b",
                     h.tag, out_keep_o, out_last_o, out_discard_o, out_data_o === h.d, h.k, h.l, h.x);
          end
          if (h.sp) begin
            checks++;  // R6
            if (in_ready_o !== 1'b0) begin
              errs++;
              $display("FAIL R6 in_ready during first half of split: got %b expected 0", in_ready_o);
            end
          end
        end
      end
      cyc++;
    end
    checks++;
    if (exp_q.size() != 0 || bi != bd_q.size()) begin
      errs++;
      $display("FAIL R6 stream incomplete: %0d beats missing, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule